// File: doc/BRIEF.md
# Serial Clock-Pulse Count Guard for Write-Class Commands

This block sits beside the command decoder of a serial three-wire EEPROM and stops a glitch on the serial clock from corrupting the array. From the start bit until chip select falls, it counts rising serial-clock events. When chip select falls, it compares that count with the exact bit length of the command that was decoded. It makes this comparison only for the four commands that change the array: single write, single erase, write-all and erase-all. A spurious extra edge moves every later address and data bit one place. Such a command therefore has the wrong length, and the guard refuses it.

All inputs are one-cycle event strobes in the system clock domain, produced by an edge detector and a command decoder upstream. The guard has a three-state controller. IDLE waits for a start bit. COUNTING follows the edges. OVERRUN is entered when the saturating count reaches its ceiling. The transitions are as follows:
- IDLE goes to COUNTING on a start strobe.
- COUNTING goes back to COUNTING on a new start strobe, which restarts the count at 1.
- COUNTING goes to OVERRUN when the next count value equals the ceiling.
- COUNTING and OVERRUN both return to IDLE on a chip-select fall.
- OVERRUN goes to COUNTING on a start strobe.

On the chip-select fall the guard gives one verdict pulse to the programming controller, either permit or abort. The pulse is combinational in that cycle.

Top module: `clk_pulse_guard`

## Requirements
- R1: After reset, permit and abort are both low and the guard is in IDLE.
- R2: With org_wide=0 and op_kind=2 (single write), exactly 18 counted edges (start edge included) give permit=1, abort=0 in the cs_fall cycle.
- R3: With org_wide=1 and op_kind=2, exactly 25 counted edges give permit=1 in the cs_fall cycle.
- R4: A gated command whose count differs from its length by any amount gives abort=1 and permit=0 in the cs_fall cycle.
- R5: Single erase (op_kind=3) and erase-all (op_kind=4) require 10 edges when org_wide=0 and 9 edges when org_wide=1.
- R6: Write-all (op_kind=5) requires 18 edges when org_wide=0 and 25 edges when org_wide=1.
- R7: For op_kind 0 (none), 1 (read), 6 (enable) and 7 (disable), a cs_fall gives neither permit nor abort, whatever the count.
- R8: The count saturates at 2**CNT_W-1. A burst long enough to wrap a plain counter back onto the command length still gives abort.
- R9: Permit and abort are never high together. Each lasts one cycle and occurs only in a cycle where cs_fall is high.
- R10: A cs_fall with no start strobe since the previous verdict gives no pulse.
- R11: A start strobe while counting restarts the count at 1, so the edges before it are discarded.
- R12: A sclk_rise in the same cycle as cs_fall is included in the compared count. In a start_det cycle, the sclk_rise is the first count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_det | input | 1 | Start bit seen on this serial clock edge (counts as edge 1) |
| sclk_rise | input | 1 | Serial clock rising edge seen |
| cs_fall | input | 1 | Chip select falling edge seen |
| op_kind | input | 3 | Decoded command: 0 none, 1 read, 2 write, 3 erase, 4 erase-all, 5 write-all, 6 enable, 7 disable |
| org_wide | input | 1 | 1 = 16-bit words, 0 = 8-bit bytes |
| permit | output | 1 | One-cycle go pulse to the programming controller |
| abort | output | 1 | One-cycle refusal pulse |

## Verification
The bench builds the guard with CNT_W=5, so the ceiling is 31 edges. This puts saturation within a few dozen serial edges. A 50-edge write burst, which a 5-bit wrapping counter would reduce to exactly 18, can then be shown to abort. The address and data widths keep their defaults, so the 18-, 25-, 10- and 9-edge lengths are exercised directly, each with neighbours one edge off on both sides.

// File: rtl/cpg_pkg.sv
package cpg_pkg;

    typedef enum logic [2:0] {
        OPK_NONE      = 3'd0,
        OPK_READ      = 3'd1,
        OPK_WRITE     = 3'd2,
        OPK_ERASE     = 3'd3,
        OPK_ERASE_ALL = 3'd4,
        OPK_WRITE_ALL = 3'd5,
        OPK_ENABLE    = 3'd6,
        OPK_DISABLE   = 3'd7
    } opk_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_COUNTING = 2'd1,
        ST_OVERRUN  = 2'd2
    } gst_e;

endpackage

// File: rtl/cpg_pulse_counter.sv
module cpg_pulse_counter #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             inc,
    input  logic             clear,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] count_ahead,
    output logic             at_max
);
    localparam logic [CNT_W-1:0] CEIL = '1;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    // value including an edge arriving this cycle, never past the ceiling
    always_comb begin
        if (inc && (count_q != CEIL)) begin
            count_ahead = count_q + ONE;
        end else begin
            count_ahead = count_q;
        end
    end

    assign at_max = (count_ahead == CEIL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= ONE;
        end else begin
            count_q <= count_ahead;
        end
    end

endmodule

// File: rtl/cpg_expect.sv
module cpg_expect
    import cpg_pkg::*;
#(
    parameter int CNT_W       = 6,
    parameter int OPC_BITS    = 2,
    parameter int ADDR_NARROW = 7,
    parameter int ADDR_WIDE   = 6,
    parameter int DATA_NARROW = 8,
    parameter int DATA_WIDE   = 16
) (
    input  logic [2:0]       op_kind,
    input  logic             org_wide,
    output logic             gated,
    output logic [CNT_W-1:0] exp_count
);
    localparam int HDR          = 1 + OPC_BITS;
    localparam int LEN_ERASE_N  = HDR + ADDR_NARROW;
    localparam int LEN_ERASE_W  = HDR + ADDR_WIDE;
    localparam int LEN_WRITE_N  = LEN_ERASE_N + DATA_NARROW;
    localparam int LEN_WRITE_W  = LEN_ERASE_W + DATA_WIDE;

    localparam logic [CNT_W-1:0] E_N = CNT_W'(LEN_ERASE_N);
    localparam logic [CNT_W-1:0] E_W = CNT_W'(LEN_ERASE_W);
    localparam logic [CNT_W-1:0] W_N = CNT_W'(LEN_WRITE_N);
    localparam logic [CNT_W-1:0] W_W = CNT_W'(LEN_WRITE_W);

    opk_e kind;
    logic [CNT_W-1:0] erase_len;
    logic [CNT_W-1:0] write_len;

    assign kind      = opk_e'(op_kind);
    assign erase_len = org_wide ? E_W : E_N;
    assign write_len = org_wide ? W_W : W_N;

    always_comb begin
        gated     = 1'b0;
        exp_count = '0;
        unique case (kind)
            OPK_WRITE, OPK_WRITE_ALL: begin
                gated     = 1'b1;
                exp_count = write_len;
            end
            OPK_ERASE, OPK_ERASE_ALL: begin
                gated     = 1'b1;
                exp_count = erase_len;
            end
            OPK_NONE, OPK_READ, OPK_ENABLE, OPK_DISABLE: begin
                gated     = 1'b0;
                exp_count = '0;
            end
            default: begin
                gated     = 1'b0;
                exp_count = '0;
            end
        endcase
    end

endmodule

// File: rtl/cpg_fsm.sv
module cpg_fsm
    import cpg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_det,
    input  logic sclk_rise,
    input  logic cs_fall,
    input  logic at_max,
    input  logic gated,
    input  logic match,
    output logic cnt_load,
    output logic cnt_inc,
    output logic cnt_clear,
    output logic permit,
    output logic abort
);
    gst_e state_q;
    gst_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_det && !cs_fall) state_d = ST_COUNTING;
            end
            ST_COUNTING: begin
                if (cs_fall)        state_d = ST_IDLE;
                else if (start_det) state_d = ST_COUNTING;
                else if (at_max)    state_d = ST_OVERRUN;
            end
            ST_OVERRUN: begin
                if (cs_fall)        state_d = ST_IDLE;
                else if (start_det) state_d = ST_COUNTING;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cnt_load  = start_det && !cs_fall;
        cnt_clear = cs_fall;
        cnt_inc   = 1'b0;
        permit    = 1'b0;
        abort     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cnt_inc = 1'b0;
            end
            ST_COUNTING: begin
                cnt_inc = sclk_rise;
                if (cs_fall && gated) begin
                    permit = match;
                    abort  = !match;
                end
            end
            ST_OVERRUN: begin
                cnt_inc = sclk_rise;
                if (cs_fall && gated) begin
                    abort = 1'b1;
                end
            end
            default: begin
                cnt_inc = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/clk_pulse_guard.sv
module clk_pulse_guard #(
    parameter int CNT_W       = 6,
    parameter int OPC_BITS    = 2,
    parameter int ADDR_NARROW = 7,
    parameter int ADDR_WIDE   = 6,
    parameter int DATA_NARROW = 8,
    parameter int DATA_WIDE   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_det,
    input  logic       sclk_rise,
    input  logic       cs_fall,
    input  logic [2:0] op_kind,
    input  logic       org_wide,
    output logic       permit,
    output logic       abort
);
    logic             cnt_load;
    logic             cnt_inc;
    logic             cnt_clear;
    logic             at_max;
    logic             gated;
    logic             match;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_ahead;
    logic [CNT_W-1:0] exp_count;

    cpg_pulse_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (cnt_load),
        .inc        (cnt_inc),
        .clear      (cnt_clear),
        .count_q    (count_q),
        .count_ahead(count_ahead),
        .at_max     (at_max)
    );

    cpg_expect #(
        .CNT_W      (CNT_W),
        .OPC_BITS   (OPC_BITS),
        .ADDR_NARROW(ADDR_NARROW),
        .ADDR_WIDE  (ADDR_WIDE),
        .DATA_NARROW(DATA_NARROW),
        .DATA_WIDE  (DATA_WIDE)
    ) u_exp (
        .op_kind  (op_kind),
        .org_wide (org_wide),
        .gated    (gated),
        .exp_count(exp_count)
    );

    assign match = (count_ahead == exp_count);

    cpg_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_det(start_det),
        .sclk_rise(sclk_rise),
        .cs_fall  (cs_fall),
        .at_max   (at_max),
        .gated    (gated),
        .match    (match),
        .cnt_load (cnt_load),
        .cnt_inc  (cnt_inc),
        .cnt_clear(cnt_clear),
        .permit   (permit),
        .abort    (abort)
    );

endmodule

// File: rtl/cpg_checker.sv
module cpg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_fall,
    input logic [2:0] op_kind,
    input logic       permit,
    input logic       abort
);
    logic write_class;
    assign write_class = (op_kind >= 3'd2) && (op_kind <= 3'd5);

    assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(permit && abort));

    assert_only_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (permit || abort) |-> cs_fall);

    assert_single_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (permit || abort) |=> !(permit || abort));

    assert_ungated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_fall && !write_class) |-> (!permit && !abort));

    assert_permit_class_R2: assert property (@(posedge clk) disable iff (!rst_n)
        permit |-> write_class);

endmodule

bind clk_pulse_guard cpg_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_fall(cs_fall),
    .op_kind(op_kind),
    .permit (permit),
    .abort  (abort)
);

// File: tb/clk_pulse_guard_tb.sv
module clk_pulse_guard_tb;
    localparam int CW = 5;

    typedef struct {
        logic  p;
        logic  a;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_det = 1'b0;
    logic       sclk_rise = 1'b0;
    logic       cs_fall = 1'b0;
    logic [2:0] op_kind = 3'd0;
    logic       org_wide = 1'b0;
    logic       permit;
    logic       abort;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #5 clk = ~clk;

    clk_pulse_guard #(.CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_det(start_det), .sclk_rise(sclk_rise),
        .cs_fall(cs_fall), .op_kind(op_kind), .org_wide(org_wide),
        .permit(permit), .abort(abort)
    );

    function automatic int len_of(input logic [2:0] k, input logic w);
        if (k == 3'd2 || k == 3'd5) return w ? 25 : 18;
        if (k == 3'd3 || k == 3'd4) return w ? 9 : 10;
        return 0;
    endfunction

    task automatic cyc(input logic s, input logic r, input logic f);
        @(negedge clk);
        start_det = s;
        sclk_rise = r;
        cs_fall   = f;
    endtask

    // driver: pushes expectation, then drives a framed command
    task automatic txn(input logic [2:0] k, input logic w, input int n,
                       input bit last_on_fall, input string tag);
        exp_t e;
        int   len;
        int   rest;
        len   = len_of(k, w);
        e.p   = (len != 0) && (n == len);
        e.a   = (len != 0) && (n != len);
        e.tag = tag;
        sb.push_back(e);
        op_kind  = k;
        org_wide = w;
        cyc(1'b1, 1'b1, 1'b0);
        rest = n - 1 - (last_on_fall ? 1 : 0);
        for (int i = 0; i < rest; i++) begin
            cyc(1'b0, 1'b1, 1'b0);
            cyc(1'b0, 1'b0, 1'b0);
        end
        cyc(1'b0, last_on_fall, 1'b1);
        cyc(1'b0, 1'b0, 1'b0);
    endtask

    task automatic finish_run;
        if (done) return;
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // monitor: sample away from the edge, compare on every chip-select fall
    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            if (cs_fall) begin
                checks++;
                if (sb.size() == 0) begin
                    errors++;
                    $display("FAIL %s: verdict with empty scoreboard p=%0b a=%0b exp p=0 a=0",
                             "R9", permit, abort);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (permit !== e.p || abort !== e.a) begin
                        errors++;
                        $display("FAIL %s: permit=%0b abort=%0b expected permit=%0b abort=%0b",
                                 e.tag, permit, abort, e.p, e.a);
                    end
                end
            end else if (permit !== 1'b0 || abort !== 1'b0) begin
                checks++;
                errors++;
                $display("FAIL R9: pulse outside cs_fall permit=%0b abort=%0b expected 0 0",
                         permit, abort);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        checks++;
        if (permit !== 1'b0 || abort !== 1'b0) begin
            errors++;
            $display("FAIL R1: reset outputs permit=%0b abort=%0b expected 0 0", permit, abort);
        end
        @(negedge clk);
        rst_n = 1'b1;
        cyc(1'b0, 1'b0, 1'b0);

        // R10: fall without a start
        begin
            exp_t e;
            e.p = 1'b0; e.a = 1'b0; e.tag = "R10";
            op_kind = 3'd2;
            sb.push_back(e);
            cyc(1'b0, 1'b0, 1'b1);
            cyc(1'b0, 1'b0, 1'b0);
        end

        txn(3'd2, 1'b0, 18, 1'b0, "R2");
        txn(3'd2, 1'b0, 19, 1'b0, "R4");
        txn(3'd2, 1'b0, 17, 1'b0, "R4");
        txn(3'd2, 1'b1, 25, 1'b0, "R3");
        txn(3'd2, 1'b1, 24, 1'b0, "R4");
        txn(3'd2, 1'b1, 26, 1'b0, "R4");
        txn(3'd3, 1'b0, 10, 1'b0, "R5");
        txn(3'd3, 1'b1, 9,  1'b0, "R5");
        txn(3'd4, 1'b0, 10, 1'b0, "R5");
        txn(3'd4, 1'b1, 10, 1'b0, "R5");
        txn(3'd4, 1'b1, 9,  1'b0, "R5");
        txn(3'd5, 1'b0, 18, 1'b0, "R6");
        txn(3'd5, 1'b1, 25, 1'b0, "R6");
        txn(3'd5, 1'b1, 18, 1'b0, "R6");
        txn(3'd1, 1'b0, 18, 1'b0, "R7");
        txn(3'd6, 1'b0, 10, 1'b0, "R7");
        txn(3'd7, 1'b1, 9,  1'b0, "R7");
        txn(3'd0, 1'b0, 4,  1'b0, "R7");
        txn(3'd2, 1'b0, 50, 1'b0, "R8");
        txn(3'd3, 1'b1, 41, 1'b0, "R8");
        txn(3'd2, 1'b0, 31, 1'b0, "R8");
        txn(3'd2, 1'b0, 18, 1'b1, "R12");
        txn(3'd3, 1'b1, 9,  1'b1, "R12");

        // R11: stray start and edges, then a fresh correct frame
        op_kind = 3'd2;
        cyc(1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 6; i++) begin
            cyc(1'b0, 1'b1, 1'b0);
        end
        txn(3'd2, 1'b0, 18, 1'b0, "R11");

        repeat (3) cyc(1'b0, 1'b0, 1'b0);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R9: %0d verdicts missing, expected 0", sb.size());
        end
        finish_run();
    end

endmodule